// File: doc/BRIEF.md
# UART with Programmable Baud Generator

This block is a full-duplex asynchronous serial port driven from a byte-wide register bus. Software programs the bit rate, the frame options and the enables. It writes a byte to start a transmission and reads received bytes back. The transmit line idles high. A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit.

Each direction has its own divider chain, and that chain restarts at the beginning of each frame. The chain is a power-of-two prescaler, then a 5-bit counter that matches a 4-bit divisor, then a divide-by-two. The match rate marks half bits. The receiver samples in the middle of each bit and rejects a start bit that does not last. It records parity, framing and overrun errors in a sticky 3-bit status field. A mode bit chooses whether a frame with an error still raises the receive interrupt. Interrupt routing and pin multiplexing sit outside the block.

Top module: `uart_core`

## Requirements
- R1: After reset, the mode register (address 0) reads 0x00, the status register (address 1) reads 0x00 and the baud register (address 4) reads 0x10. The transmit line is high and both interrupt outputs are low.
- R2: The baud register holds a prescale code in bits [6:4] and a divisor in bits [3:0]. With prescale value P = 2^(code+1), where code 7 is treated as 6, and divisor D, every transmitted bit lasts 4·P/2·(D+1) = 2·P·(D+1) system cycles.
- R3: Writing address 2 while transmission is enabled (mode bit 7) and the transmitter is idle sends the byte. The frame is a low start bit, 8 data bits LSB first, a parity bit when mode bit 5 is set and a high stop bit. Parity is even when mode bit 4 is 0 and odd when it is 1. The transmit interrupt is a one-cycle pulse at the end of the stop bit.
- R4: A write to address 2 is ignored when mode bit 7 is clear, and it is ignored while a frame is being sent.
- R5: With reception enabled (mode bit 6), a frame on the receive line is sampled at mid-bit. Its byte becomes readable at address 3, and the receive interrupt pulses for one cycle.
- R6: A low pulse on the receive line that ends before the middle of the start bit is discarded, with no interrupt and no status change.
- R7: A low stop bit sets status bit 1 (framing error).
- R8: With parity enabled, a parity bit that does not match the configured sense sets status bit 0 (parity error).
- R9: If a frame completes while the previous byte is still unread, status bit 2 (overrun) is set, and address 3 then holds the newer byte.
- R10: When mode bit 0 is 1, a frame with any error raises no receive interrupt. When mode bit 0 is 0, such a frame still raises one.
- R11: Reading the status register clears its error bits. A second read returns 0.
- R12: With mode bit 6 clear, activity on the receive line raises no interrupt and leaves the receive data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| rx_irq_o | output | 1 | Receive-complete interrupt pulse |
| tx_irq_o | output | 1 | Transmit-complete interrupt pulse |

## Verification
The bench keeps the default widths: 3-bit prescale code, 4-bit divisor, 5-bit match counter and 8 data bits. Most stimulus runs with a 4-cycle half bit (prescale code 0, divisor 1), which keeps the many random loopback frames short. Bit lengths of 64 and 256 cycles are measured as well, the 256-cycle case using prescale code 7, so the code-7 clamp of the prescaler is also reached. Error frames are built by hand: a flipped parity bit, a low stop bit, a short false start and two frames with no read between them.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } frame_st_e;

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_TXD  = 3'd2;
  localparam logic [2:0] ADDR_RXD  = 3'd3;
  localparam logic [2:0] ADDR_BAUD = 3'd4;
endpackage

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
  parameter int PS_W  = 3,
  parameter int DIV_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [PRE_W:0]   pre_full;
  logic [PS_W-1:0]  ps_eff;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_tick;

  always_comb begin
    // top code would overflow the prescaler, fold it onto the largest ratio
    ps_eff   = (ps_i == PS_W'(PRE_W)) ? PS_W'(PRE_W - 1) : ps_i;
    pre_full = (PRE_W+1)'(1) << (ps_eff + 1'b1);
    pre_lim  = PRE_W'(pre_full - 1'b1);
  end

  assign pre_tick = (pre_q == pre_lim);
  assign tick_o   = pre_tick && (cnt_q == CNT_W'(div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_tick) begin
      pre_q <= '0;
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assert_restart_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          restart_o,
  output logic          txd_o,
  output logic          done_o
);
  localparam int BC_W = $clog2(DW);

  frame_st_e       st_q;
  logic [DW-1:0]   sh_q;
  logic [BC_W-1:0] bc_q;
  logic            ph_q, par_q, pen_q, txd_q, done_q;

  assign restart_o = start_i && (st_q == ST_IDLE);
  assign txd_o     = txd_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bc_q   <= '0;
      ph_q   <= 1'b0;
      par_q  <= 1'b0;
      pen_q  <= 1'b0;
      txd_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (restart_o) begin
        st_q  <= ST_START;
        sh_q  <= data_i;
        bc_q  <= '0;
        ph_q  <= 1'b0;
        par_q <= ^data_i ^ par_odd_i;
        pen_q <= par_en_i;
        txd_q <= 1'b0;
      end else if (st_q != ST_IDLE && tick_i) begin
        ph_q <= ~ph_q;
        if (ph_q) begin
          unique case (st_q)
            ST_START: begin
              st_q  <= ST_DATA;
              txd_q <= sh_q[0];
            end
            ST_DATA: begin
              sh_q <= sh_q >> 1;
              if (bc_q == BC_W'(DW - 1)) begin
                st_q  <= pen_q ? ST_PAR : ST_STOP;
                txd_q <= pen_q ? par_q : 1'b1;
              end else begin
                bc_q  <= bc_q + 1'b1;
                txd_q <= sh_q[1];
              end
            end
            ST_PAR: begin
              st_q  <= ST_STOP;
              txd_q <= 1'b1;
            end
            default: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START) |-> !txd_o);
  assert_stop_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STOP || st_q == ST_IDLE) |-> txd_o);
  assert_busy_ignore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q != ST_IDLE) |=> $stable(par_q));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          rxd_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          restart_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int BC_W = $clog2(DW);

  frame_st_e       st_q;
  logic [DW-1:0]   sh_q, data_q;
  logic [BC_W-1:0] bc_q;
  logic            ph_q, pen_q, odd_q, pbit_q, done_q, perr_q, ferr_q;
  logic            sample;

  assign restart_o = en_i && (st_q == ST_IDLE) && !rxd_i;
  assign sample    = tick_i && !ph_q;
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign perr_o    = perr_q;
  assign ferr_o    = ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      data_q <= '0;
      bc_q   <= '0;
      ph_q   <= 1'b0;
      pen_q  <= 1'b0;
      odd_q  <= 1'b0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (restart_o) begin
        st_q  <= ST_START;
        ph_q  <= 1'b0;
        bc_q  <= '0;
        pen_q <= par_en_i;
        odd_q <= par_odd_i;
      end else if (st_q != ST_IDLE && tick_i) begin
        ph_q <= ~ph_q;
        if (sample) begin
          unique case (st_q)
            ST_START: st_q <= rxd_i ? ST_IDLE : ST_DATA;
            ST_DATA: begin
              sh_q <= {rxd_i, sh_q[DW-1:1]};
              if (bc_q == BC_W'(DW - 1)) st_q <= pen_q ? ST_PAR : ST_STOP;
              else                       bc_q <= bc_q + 1'b1;
            end
            ST_PAR: begin
              pbit_q <= rxd_i;
              st_q   <= ST_STOP;
            end
            default: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              data_q <= sh_q;
              ferr_q <= !rxd_i;
              perr_q <= pen_q && (^sh_q ^ pbit_q ^ odd_q);
            end
          endcase
        end
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_false_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START && sample && rxd_i) |=> (st_q == ST_IDLE && !done_q));
  assert_no_perr_wo_parity_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !pen_q) |-> !perr_q);
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PS_W  = 3,
  parameter int DIV_W = 4,
  parameter int CNT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_sel_i,
  input  logic       bus_we_i,
  input  logic [2:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       rx_irq_o,
  output logic       tx_irq_o
);
  localparam int BAUD_W = PS_W + DIV_W;
  localparam logic [BAUD_W-1:0] BAUD_RST = BAUD_W'(1) << DIV_W;

  logic [7:0]        mode_q;
  logic [BAUD_W-1:0] baud_q;
  logic [2:0]        stat_q;
  logic              full_q, irq_q;
  logic [1:0]        rsync_q;
  logic              wr, rd, wr_tx, rd_stat, rd_rx;
  logic [1:0]        restart, tick;
  logic              rx_done, rx_perr, rx_ferr, ovr_now, err_now;
  logic [DW-1:0]     rx_data;

  assign wr      = bus_sel_i && bus_we_i;
  assign rd      = bus_sel_i && !bus_we_i;
  assign wr_tx   = wr && (bus_addr_i == ADDR_TXD) && mode_q[7];
  assign rd_stat = rd && (bus_addr_i == ADDR_STAT);
  assign rd_rx   = rd && (bus_addr_i == ADDR_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      baud_q <= BAUD_RST;
    end else if (wr) begin
      if (bus_addr_i == ADDR_MODE) mode_q <= bus_wdata_i;
      if (bus_addr_i == ADDR_BAUD) baud_q <= bus_wdata_i[BAUD_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b11;
    else         rsync_q <= {rsync_q[0], rxd_i};
  end

  // index 0: transmit chain, index 1: receive chain
  for (genvar g = 0; g < 2; g++) begin : g_div
    uart_baud_div #(.PS_W(PS_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(restart[g]),
      .ps_i     (baud_q[BAUD_W-1:DIV_W]),
      .div_i    (baud_q[DIV_W-1:0]),
      .tick_o   (tick[g])
    );
  end

  uart_tx #(.DW(DW)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick[0]),
    .start_i  (wr_tx),
    .data_i   (bus_wdata_i[DW-1:0]),
    .par_en_i (mode_q[5]),
    .par_odd_i(mode_q[4]),
    .restart_o(restart[0]),
    .txd_o    (txd_o),
    .done_o   (tx_irq_o)
  );

  uart_rx #(.DW(DW)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick[1]),
    .en_i     (mode_q[6]),
    .rxd_i    (rsync_q[1]),
    .par_en_i (mode_q[5]),
    .par_odd_i(mode_q[4]),
    .restart_o(restart[1]),
    .done_o   (rx_done),
    .data_o   (rx_data),
    .perr_o   (rx_perr),
    .ferr_o   (rx_ferr)
  );

  assign ovr_now = full_q && !rd_rx;
  assign err_now = rx_perr || rx_ferr || ovr_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= rx_done && !(mode_q[0] && err_now);
      if (rx_done)
        stat_q <= (rd_stat ? 3'b000 : stat_q) | {ovr_now, rx_ferr, rx_perr};
      else if (rd_stat)
        stat_q <= '0;
      if (rx_done)    full_q <= 1'b1;
      else if (rd_rx) full_q <= 1'b0;
    end
  end

  assign rx_irq_o = irq_q;

  always_comb begin
    unique case (bus_addr_i)
      ADDR_MODE: bus_rdata_o = mode_q;
      ADDR_STAT: bus_rdata_o = {5'b0, stat_q};
      ADDR_RXD:  bus_rdata_o = 8'(rx_data);
      ADDR_BAUD: bus_rdata_o = 8'(baud_q);
      default:   bus_rdata_o = '0;
    endcase
  end

  assert_stat_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !rx_done) |=> (stat_q == 3'b000));
  assert_err_suppress_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && mode_q[0] && (rx_perr || rx_ferr)) |=> !rx_irq_o);
  assert_irq_needs_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(rx_done));
  assert_overrun_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && full_q && !rd_rx) |=> stat_q[2]);
endmodule

// File: tb/sim_uart_core.sv
module sim_uart_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd_drv = 1'b1, loop = 1'b0;
  logic       rxd, txd, rx_irq, tx_irq;
  int         checks = 0, errors = 0, cyc = 0;
  int         rx_cnt = 0, tx_cnt = 0;

  assign rxd = loop ? txd : rxd_drv;

  uart_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rxd_i(rxd), .txd_o(txd), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rx_irq) rx_cnt++;
    if (tx_irq) tx_cnt++;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  function automatic logic par_of(input logic [7:0] b, input bit odd);
    return ^b ^ odd;
  endfunction

  function automatic int bit_len(input int ps, input int dv);
    int p = (ps == 7) ? 128 : (1 << (ps + 1));
    return 2 * p * (dv + 1);
  endfunction

  task automatic wait_rx(input int old, input int lim);
    for (int i = 0; i < lim && rx_cnt == old; i++) begin @(negedge clk); #2; end
  endtask

  task automatic wait_tx(input int old, input int lim);
    for (int i = 0; i < lim && tx_cnt == old; i++) begin @(negedge clk); #2; end
  endtask

  task automatic cap_tx(input int bl, input bit pen, output logic [7:0] b,
                        output logic p, output logic stp, output bit found);
    found = 0; b = '0; p = 0; stp = 0;
    for (int i = 0; i < 40 * bl && !found; i++) begin
      @(negedge clk);
      if (!txd) found = 1;
    end
    if (found) begin
      repeat (bl / 2) @(negedge clk);
      if (txd) found = 0;
      for (int i = 0; i < 8; i++) begin repeat (bl) @(negedge clk); b[i] = txd; end
      if (pen) begin repeat (bl) @(negedge clk); p = txd; end
      repeat (bl) @(negedge clk); stp = txd;
      repeat (bl) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit pen, input bit odd,
                            input bit bad_par, input logic stop_v, input int bl);
    @(negedge clk); rxd_drv = 0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_drv = b[i]; repeat (bl) @(negedge clk); end
    if (pen) begin rxd_drv = par_of(b, odd) ^ bad_par; repeat (bl) @(negedge clk); end
    rxd_drv = stop_v; repeat (bl) @(negedge clk);
    rxd_drv = 1; repeat (2 * bl) @(negedge clk);
  endtask

  task automatic tx_check(input string tag, input logic [7:0] b, input bit pen,
                          input bit odd, input int bl);
    logic [7:0] got; logic p, s; bit f; int old;
    old = tx_cnt;
    bus_wr(3'd2, b);
    cap_tx(bl, pen, got, p, s, f);
    chk(f && got == b, {tag, " data"}, got, b);
    if (pen) chk(p == par_of(b, odd), {tag, " parity"}, p, par_of(b, odd));
    chk(s == 1'b1, {tag, " stop"}, s, 1);
    wait_tx(old, 4 * bl);
    chk(tx_cnt == old + 1, {tag, " tx irq"}, tx_cnt - old, 1);
  endtask

  task automatic measure_start(input string tag, input int exp);
    int n = 0; int old = tx_cnt;
    bus_wr(3'd2, 8'hFF);
    for (int i = 0; i < 4 * exp && txd; i++) @(negedge clk);
    while (!txd && n < 4 * exp) begin n++; @(negedge clk); end
    chk(n == exp, tag, n, exp);
    wait_tx(old, 20 * exp);
  endtask

  logic [7:0] r, prev;
  int old_rx, old_tx, low_seen;

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(!rx_irq && !tx_irq, "R1 irq low", {rx_irq, tx_irq}, 0);
    bus_rd(3'd0, r); chk(r == 8'h00, "R1 mode", r, 8'h00);
    bus_rd(3'd1, r); chk(r == 8'h00, "R1 status", r, 8'h00);
    bus_rd(3'd4, r); chk(r == 8'h10, "R1 baud", r, 8'h10);

    // R2 bit length over three baud settings, incl. clamped prescale code 7
    bus_wr(3'd0, 8'hC0);
    bus_wr(3'd4, 8'h01); measure_start("R2 ps0 div1", bit_len(0, 1));
    bus_wr(3'd4, 8'h23); measure_start("R2 ps2 div3", bit_len(2, 3));
    bus_wr(3'd4, 8'h70); measure_start("R2 ps7 div0", bit_len(7, 0));
    bus_wr(3'd4, 8'h01);

    // R3 directed frames
    tx_check("R3 plain", 8'hA5, 0, 0, 8);
    bus_wr(3'd0, 8'hE0); tx_check("R3 even", 8'h37, 1, 0, 8);
    bus_wr(3'd0, 8'hF0); tx_check("R3 odd", 8'h37, 1, 1, 8);

    // R4 write with transmit disabled
    bus_wr(3'd0, 8'h40);
    old_tx = tx_cnt; low_seen = 0;
    bus_wr(3'd2, 8'h00);
    repeat (40) begin @(negedge clk); if (!txd) low_seen++; end
    chk(low_seen == 0, "R4 disabled line", low_seen, 0);
    chk(tx_cnt == old_tx, "R4 disabled irq", tx_cnt - old_tx, 0);
    // R4 write while busy
    bus_wr(3'd0, 8'hC0);
    old_tx = tx_cnt;
    bus_wr(3'd2, 8'h3C);
    bus_wr(3'd2, 8'hC3);
    begin
      logic [7:0] g; logic p, s; bit f;
      cap_tx(8, 0, g, p, s, f);
      chk(f && g == 8'h3C, "R4 busy keeps first", g, 8'h3C);
    end
    low_seen = 0;
    repeat (40) begin @(negedge clk); if (!txd) low_seen++; end
    chk(low_seen == 0 && tx_cnt == old_tx + 1, "R4 busy second dropped",
        tx_cnt - old_tx, 1);

    // R5 receive
    old_rx = rx_cnt;
    send_frame(8'h5A, 0, 0, 0, 1, 8);
    chk(rx_cnt == old_rx + 1, "R5 irq", rx_cnt - old_rx, 1);
    bus_rd(3'd3, r); chk(r == 8'h5A, "R5 data", r, 8'h5A);
    bus_rd(3'd1, r); chk(r == 8'h00, "R5 status", r, 0);

    // R6 false start
    old_rx = rx_cnt;
    @(negedge clk); rxd_drv = 0; repeat (2) @(negedge clk); rxd_drv = 1;
    repeat (30) @(negedge clk);
    chk(rx_cnt == old_rx, "R6 no irq", rx_cnt - old_rx, 0);
    bus_rd(3'd1, r); chk(r == 8'h00, "R6 status", r, 0);

    // R7 framing error, R10 with mask clear still raises irq
    old_rx = rx_cnt;
    send_frame(8'h11, 0, 0, 0, 0, 8);
    chk(rx_cnt == old_rx + 1, "R10 unmasked error irq", rx_cnt - old_rx, 1);
    bus_rd(3'd1, r); chk(r == 8'h02, "R7 framing", r, 2);
    bus_rd(3'd3, r);

    // R8 parity error then good parity
    bus_wr(3'd0, 8'hE0);
    send_frame(8'h22, 1, 0, 1, 1, 8);
    bus_rd(3'd1, r); chk(r == 8'h01, "R8 parity error", r, 1);
    bus_rd(3'd3, r);
    send_frame(8'h23, 1, 0, 0, 1, 8);
    bus_rd(3'd1, r); chk(r == 8'h00, "R8 good parity", r, 0);
    bus_rd(3'd3, r); chk(r == 8'h23, "R8 data", r, 8'h23);

    // R10 masked error frame
    bus_wr(3'd0, 8'hC1);
    old_rx = rx_cnt;
    send_frame(8'h44, 0, 0, 0, 0, 8);
    chk(rx_cnt == old_rx, "R10 masked error", rx_cnt - old_rx, 0);
    bus_rd(3'd1, r); chk(r == 8'h02, "R10 status kept", r, 2);
    bus_rd(3'd3, r);
    old_rx = rx_cnt;
    send_frame(8'h45, 0, 0, 0, 1, 8);
    chk(rx_cnt == old_rx + 1, "R10 masked good frame", rx_cnt - old_rx, 1);
    bus_rd(3'd3, r);

    // R9 overrun, R11 clear on read
    bus_wr(3'd0, 8'hC0);
    send_frame(8'h10, 0, 0, 0, 1, 8);
    send_frame(8'h20, 0, 0, 0, 1, 8);
    bus_rd(3'd1, r); chk(r == 8'h04, "R9 overrun", r, 4);
    bus_rd(3'd1, r); chk(r == 8'h00, "R11 cleared", r, 0);
    bus_rd(3'd3, prev); chk(prev == 8'h20, "R9 newer byte", prev, 8'h20);

    // R12 receiver disabled
    bus_wr(3'd0, 8'h80);
    old_rx = rx_cnt;
    send_frame(8'h99, 0, 0, 0, 1, 8);
    chk(rx_cnt == old_rx, "R12 no irq", rx_cnt - old_rx, 0);
    bus_rd(3'd3, r); chk(r == prev, "R12 data unchanged", r, prev);

    // R3 R5 R8 random loopback
    loop = 1;
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b, m;
      b = 8'($urandom);
      m = 8'hC0 | 8'(($urandom % 4) << 4);
      bus_wr(3'd0, m);
      old_rx = rx_cnt; old_tx = tx_cnt;
      bus_wr(3'd2, b);
      wait_rx(old_rx, 200);
      wait_tx(old_tx, 200);
      chk(rx_cnt == old_rx + 1, "R5 loop irq", rx_cnt - old_rx, 1);
      bus_rd(3'd3, r); chk(r == b, "R3 loop data", r, b);
      bus_rd(3'd1, r); chk(r == 8'h00, "R8 loop status", r, 0);
    end
    loop = 0;

    finish_run();
  end
endmodule